// File: doc/BRIEF.md
# PWM Carrier Chopper

The chopper sits between a PWM generator and the gate drivers of an isolated power stage. Pulse transformers cannot pass long DC-level pulses, so each high phase of a PWM channel is cut into a train of short pulses that a transformer can couple. Each channel opens its high phase with one wider pulse, which builds gate charge quickly, and then passes a high-frequency carrier for as long as the input stays high.

The block has one global on/off bit and three shared configuration fields. The carrier is derived from the system clock. A base period of eight clocks is stretched by a 3-bit frequency code, and the high time within a period is set in eighths by a 3-bit duty code. A 4-bit width code sets the leading pulse in steps of eight clocks. The channels share this configuration but run their own timers, so their edges never need to line up.

Top module: `pwm_chopper`

## Requirements
- R1: While `chop_en` is 0, each output equals its input in the same cycle, whatever the configuration.
- R2: While `chop_en` is 1, a rising input starts a first pulse: the output is high for 8*(`shot_width`+1) clocks, counted from the first cycle in which the input is high.
- R3: After the first pulse the output follows a carrier whose period is 8*(`freq_sel`+1) clocks. The carrier phase restarts at the cycle right after the first pulse, and that cycle is the start of a high time.
- R4: Within each carrier period the output is high for the first (`duty_sel`+1)*(`freq_sel`+1) clocks and low for the rest, provided the input stays high.
- R5: Duty code 7 behaves exactly like duty code 6, so the high time is 7*(`freq_sel`+1) clocks.
- R6: An input that is low forces its output low in that same cycle. The fall cancels the first pulse or the carrier, and the next rising input starts a new first pulse.
- R7: Each channel times its first pulse and carrier phase from its own rising edge, independently of the other channel.
- R8: During reset with inputs low, both outputs are low. The first input high after reset starts a fresh first pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chop_en | input | 1 | 1 = chop the inputs, 0 = pass them through |
| freq_sel | input | 3 | Carrier divider code n, dividing by n+1 |
| duty_sel | input | 3 | Carrier high time in eighths, code+1 (7 acts as 6) |
| shot_width | input | 4 | First-pulse width code w, giving 8*(w+1) clocks |
| pwm_in | input | 2 | PWM channels to be chopped |
| pwm_out | output | 2 | Chopped channels |

## Verification
Each output is a combinational function of the present input and of registered timer state. A change at an input therefore appears at its output in the same cycle: pass-through, a fall forcing the output low, and a rise starting the first pulse all show up at once. Timer-driven transitions happen on clock edges: the end of the first pulse 8*(w+1) cycles after the rise, and each carrier edge after that. The bench drives inputs just after a falling clock edge and samples 1 ns later. It keeps for each channel the number of cycles since that channel's last rise, and from this count it works out the expected level for every channel in every cycle. Configuration is changed only while both inputs are low, so a whole high phase runs under one setting.

// File: rtl/chop_pkg.sv
// Shared constants and types for the PWM carrier chopper.
// Assumes the carrier base is a fixed number of system clocks per period,
// and that the duty is expressed in units of one base step.
package chop_pkg;
    localparam int BASE_DIV = 8;

    // Which source drives a channel output in the current cycle.
    typedef enum logic [1:0] {
        SRC_PASS    = 2'd0,
        SRC_SHOT    = 2'd1,
        SRC_CARRIER = 2'd2
    } out_src_t;
endpackage

// File: rtl/chop_cfg_decode.sv
// Turns the configuration codes into clock counts that all channels share:
// the first-pulse length, the carrier period and the carrier high time.
// Assumes the highest duty code is reserved and maps it to the one below.
module chop_cfg_decode
    import chop_pkg::*;
#(
    parameter int FREQ_W = 3,
    parameter int DUTY_W = 3,
    parameter int WID_W  = 4,
    parameter int OS_W   = 8,
    parameter int CAR_W  = 7
) (
    input  logic [FREQ_W-1:0] freq_sel,
    input  logic [DUTY_W-1:0] duty_sel,
    input  logic [WID_W-1:0]  shot_width,
    output logic [OS_W-1:0]   shot_len,
    output logic [CAR_W-1:0]  car_period,
    output logic [CAR_W-1:0]  car_high
);
    localparam logic [DUTY_W-1:0] DUTY_TOP = '1;

    logic [DUTY_W-1:0] duty_eff;

    // Clamp the reserved duty code onto the largest legal one.
    always_comb begin
        duty_eff = (duty_sel == DUTY_TOP) ? duty_sel - 1'b1 : duty_sel;
    end

    // Scale each code into a clock count.
    always_comb begin
        shot_len   = OS_W'(BASE_DIV) * (OS_W'(shot_width) + 1'b1);
        car_period = CAR_W'(BASE_DIV) * (CAR_W'(freq_sel) + 1'b1);
        car_high   = (CAR_W'(duty_eff) + 1'b1) * (CAR_W'(freq_sel) + 1'b1);
    end
endmodule

// File: rtl/chop_oneshot.sv
// First-pulse timer for one channel. It detects the rising input and holds
// busy for the rest of the pulse, then raises expire in the pulse's last
// cycle. Assumes shot_len is at least 2 and stays fixed while the input is high.
module chop_oneshot #(
    parameter int OS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sig_in,
    input  logic [OS_W-1:0] shot_len,
    output logic            rise,
    output logic            busy,
    output logic            expire
);
    logic            in_q;
    logic [OS_W-1:0] cnt;

    assign rise   = sig_in & ~in_q;
    assign expire = busy & sig_in & (cnt >= shot_len - 1'b1);

    // Track the previous input and count the cycles of the first pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q <= 1'b0;
            busy <= 1'b0;
            cnt  <= '0;
        end else begin
            in_q <= sig_in;
            if (!sig_in) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else if (rise) begin
                busy <= 1'b1;
                cnt  <= OS_W'(1);
            end else if (expire) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else if (busy) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assert_rise_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> busy);

    assert_shot_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $stable(shot_len)) |-> (cnt < shot_len));
endmodule

// File: rtl/chop_carrier.sv
// Carrier phase counter for one channel. The start pulse restarts the phase
// at zero, the counter wraps every car_period clocks, and level is high in the
// first car_high clocks of each period. Assumes car_period is at least 8.
module chop_carrier #(
    parameter int CAR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    input  logic             start,
    input  logic [CAR_W-1:0] car_period,
    input  logic [CAR_W-1:0] car_high,
    output logic             active,
    output logic             level
);
    logic [CAR_W-1:0] cnt;

    assign level = active & (cnt < car_high);

    // Run the carrier phase from the end of the first pulse until the input falls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (!sig_in) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active) begin
            cnt <= (cnt >= car_period - 1'b1) ? '0 : cnt + 1'b1;
        end
    end

    assert_phase_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> (cnt == '0));

    assert_phase_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $stable(car_period)) |-> (cnt < car_period));
endmodule

// File: rtl/pwm_chopper.sv
// PWM carrier chopper. Each channel opens its high phase with a wide first
// pulse and then gates the input with a divided carrier. Assumes the
// configuration changes only while the inputs are low. Outputs are
// combinational on the input, so a falling input takes effect at once.
module pwm_chopper
    import chop_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int FREQ_W = 3,
    parameter int DUTY_W = 3,
    parameter int WID_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chop_en,
    input  logic [FREQ_W-1:0] freq_sel,
    input  logic [DUTY_W-1:0] duty_sel,
    input  logic [WID_W-1:0]  shot_width,
    input  logic [NCH-1:0]    pwm_in,
    output logic [NCH-1:0]    pwm_out
);
    localparam int OS_W  = $clog2(BASE_DIV * (1 << WID_W)) + 1;
    localparam int CAR_W = $clog2(BASE_DIV * (1 << FREQ_W)) + 1;

    logic [OS_W-1:0]  shot_len;
    logic [CAR_W-1:0] car_period;
    logic [CAR_W-1:0] car_high;

    chop_cfg_decode #(
        .FREQ_W(FREQ_W), .DUTY_W(DUTY_W), .WID_W(WID_W),
        .OS_W(OS_W), .CAR_W(CAR_W)
    ) u_cfg (
        .freq_sel   (freq_sel),
        .duty_sel   (duty_sel),
        .shot_width (shot_width),
        .shot_len   (shot_len),
        .car_period (car_period),
        .car_high   (car_high)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic     rise, busy, expire, active, level;
        out_src_t src;

        chop_oneshot #(.OS_W(OS_W)) u_shot (
            .clk      (clk),
            .rst_n    (rst_n),
            .sig_in   (pwm_in[g]),
            .shot_len (shot_len),
            .rise     (rise),
            .busy     (busy),
            .expire   (expire)
        );

        chop_carrier #(.CAR_W(CAR_W)) u_car (
            .clk        (clk),
            .rst_n      (rst_n),
            .sig_in     (pwm_in[g]),
            .start      (expire),
            .car_period (car_period),
            .car_high   (car_high),
            .active     (active),
            .level      (level)
        );

        // Pick the output source: bypass, first pulse, or carrier.
        always_comb begin
            if (!chop_en)           src = SRC_PASS;
            else if (rise || busy)  src = SRC_SHOT;
            else                    src = SRC_CARRIER;
        end

        // Form the channel output from the selected source.
        always_comb begin
            case (src)
                SRC_PASS:    pwm_out[g] = pwm_in[g];
                SRC_SHOT:    pwm_out[g] = pwm_in[g];
                SRC_CARRIER: pwm_out[g] = pwm_in[g] & level;
                default:     pwm_out[g] = 1'b0;
            endcase
        end

        assert_low_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !pwm_in[g] |-> !pwm_out[g]);
    end
endmodule

// File: tb/tb_pwm_chopper.sv
module tb_pwm_chopper;
    localparam time CLK_PERIOD = 10;
    localparam int  NCH = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           chop_en = 1'b0;
    logic [2:0]     freq_sel = '0;
    logic [2:0]     duty_sel = '0;
    logic [3:0]     shot_width = '0;
    logic [NCH-1:0] pwm_in = '0;
    logic [NCH-1:0] pwm_out;

    int checks = 0;
    int failures = 0;
    int prev_in [NCH];
    int since   [NCH];

    pwm_chopper dut (
        .clk(clk), .rst_n(rst_n), .chop_en(chop_en), .freq_sel(freq_sel),
        .duty_sel(duty_sel), .shot_width(shot_width), .pwm_in(pwm_in),
        .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Expected level from the requirements: cycles since the rise decide it.
    function automatic logic model_out(int ch, int k);
        int shot, per, d, hi;
        if (!chop_en) return pwm_in[ch];
        if (!pwm_in[ch]) return 1'b0;
        shot = 8 * (int'(shot_width) + 1);
        per  = 8 * (int'(freq_sel) + 1);
        d    = (duty_sel == 3'd7) ? 6 : int'(duty_sel);
        hi   = (d + 1) * (int'(freq_sel) + 1);
        if (k < shot) return 1'b1;
        return (((k - shot) % per) < hi) ? 1'b1 : 1'b0;
    endfunction

    // Drive one cycle, compare every channel, then advance the model.
    task automatic step(input logic [NCH-1:0] pat, input string tag);
        @(negedge clk);
        pwm_in = pat;
        #1;
        for (int ch = 0; ch < NCH; ch++) begin
            int  k;
            logic exp_v;
            k = (pwm_in[ch] && prev_in[ch] == 0) ? 0 : since[ch];
            exp_v = model_out(ch, k);
            checks++;
            if (pwm_out[ch] !== exp_v) begin
                failures++;
                $display("FAIL %s ch%0d k=%0d: actual=%b expected=%b", tag, ch, k, pwm_out[ch], exp_v);
            end
            since[ch]   = pwm_in[ch] ? k + 1 : 0;
            prev_in[ch] = pwm_in[ch];
        end
    endtask

    task automatic hold(input logic [NCH-1:0] pat, input int n, input string tag);
        for (int i = 0; i < n; i++) step(pat, tag);
    endtask

    task automatic config_set(input logic en, input int f, input int d, input int w);
        hold('0, 3, "idle");
        chop_en    = en;
        freq_sel   = 3'(f);
        duty_sel   = 3'(d);
        shot_width = 4'(w);
        hold('0, 2, "idle");
    endtask

    initial begin
        for (int ch = 0; ch < NCH; ch++) begin
            prev_in[ch] = 0;
            since[ch]   = 0;
        end
        // R8: outputs low during reset with inputs low
        chop_en = 1'b1;
        repeat (3) begin
            @(negedge clk);
            #1;
            checks++;
            if (pwm_out !== '0) begin
                failures++;
                $display("FAIL R8 reset: actual=%b expected=00", pwm_out);
            end
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R8 / R2 / R3 / R4: first high after reset, f=0 d=3 w=0
        config_set(1, 0, 3, 0);
        hold(2'b01, 60, "R8_R2_R4");
        hold(2'b00, 4, "R6");

        // R1: bypass with busy configuration
        config_set(0, 5, 2, 3);
        hold(2'b11, 7, "R1");
        hold(2'b01, 3, "R1");
        hold(2'b10, 5, "R1");
        hold(2'b00, 2, "R1");
        hold(2'b11, 40, "R1");

        // R3 / R4: divided carrier f=2 d=1 w=1
        config_set(1, 2, 1, 1);
        hold(2'b11, 110, "R3_R4");

        // R5: reserved duty code behaves like 6
        config_set(1, 1, 7, 0);
        hold(2'b01, 60, "R5");
        config_set(1, 1, 6, 0);
        hold(2'b01, 60, "R5");

        // R6: fall in the middle of the first pulse, then a new rise
        config_set(1, 0, 0, 2);
        hold(2'b01, 10, "R6");
        hold(2'b00, 1, "R6");
        hold(2'b01, 40, "R6");
        hold(2'b00, 2, "R6");
        // R6: fall during chopping, then a new rise
        hold(2'b11, 30, "R6");
        hold(2'b00, 1, "R6");
        hold(2'b11, 35, "R6");

        // R7: staggered channels with independent phases
        config_set(1, 1, 2, 0);
        hold(2'b01, 5, "R7");
        hold(2'b11, 50, "R7");
        hold(2'b10, 3, "R7");
        hold(2'b11, 40, "R7");

        // R2 / R3: longest settings
        config_set(1, 7, 6, 15);
        hold(2'b11, 260, "R2_R3");
        hold(2'b00, 3, "R6");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule